// File: doc/BRIEF.md
# Wishbone to CSR Width Down-Converter

This block sits between a Wishbone classic slave port of width k and a narrower (or equally wide) CSR register bus of width n, with k an integer multiple of n. Every Wishbone cycle becomes a fixed run of k/n CSR accesses, one per clock, at consecutive CSR addresses. Reads collect the returned chunks into one Wishbone word. Writes cut the Wishbone word into chunks and hand them out least significant first.

The converter has a fixed latency. It ignores byte selects: every chunk is always accessed, and the cycle count never varies. The final write strobe is placed one cycle before the acknowledge. A register multiplexer that commits one cycle after its last write strobe therefore updates the register in the same cycle as the Wishbone acknowledge. Burst cycle types, error and retry responses, and the register multiplexer itself are not part of this block.

Top module: `wb_csr_bridge`

## Requirements
- R1: Each Wishbone cycle issues exactly RATIO = WB_DATA_W/CSR_DATA_W CSR strobes, one per clock, in the first RATIO cycles that `wb_cyc` and `wb_stb` are high. `csr_r_stb` is used when `wb_we` is 0 and `csr_w_stb` when it is 1.
- R2: `wb_ack` rises exactly RATIO cycles after the first cycle of the request, so an access spans RATIO+1 cycles. It lasts one cycle, and the block is then idle.
- R3: The strobe for chunk i carries `csr_addr` = `wb_adr`*RATIO + i. Chunk i is bits [i*CSR_DATA_W +: CSR_DATA_W], counted from the least significant end.
- R4: During a write, chunk i of `wb_dat_w` is driven on `csr_w_data` together with the strobe for address `wb_adr`*RATIO + i.
- R5: In the acknowledge cycle of a read, `wb_dat_r` holds chunk i equal to the `csr_r_data` value present one cycle after the i-th read strobe.
- R6: `wb_sel` has no effect. Any select value gives the same latency, the same strobe count and the same data.
- R7: No CSR strobe is issued unless `wb_cyc` and `wb_stb` are both high. Dropping either before the acknowledge abandons the access with no `wb_ack`, and the next request starts again from chunk 0.
- R8: On a write, the strobe for the last chunk comes exactly one cycle before `wb_ack`.
- R9: While `rst` is high, no strobe and no `wb_ack` is driven, whatever the bus inputs are.
- R10: When WB_DATA_W equals CSR_DATA_W, one CSR access is made at address `wb_adr`, and `wb_ack` follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr | input | WB_ADDR_W | Wishbone word address |
| wb_dat_w | input | WB_DATA_W | Wishbone write data |
| wb_dat_r | output | WB_DATA_W | Wishbone read data, valid with `wb_ack` |
| wb_sel | input | WB_DATA_W/8 | Byte selects (ignored) |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_ack | output | 1 | Wishbone acknowledge |
| csr_addr | output | WB_ADDR_W+log2(RATIO) | CSR chunk address |
| csr_r_stb | output | 1 | CSR read strobe |
| csr_r_data | input | CSR_DATA_W | CSR read data, one cycle after `csr_r_stb` |
| csr_w_stb | output | 1 | CSR write strobe |
| csr_w_data | output | CSR_DATA_W | CSR write data |

## Verification
Each request is driven just after a falling edge. The bench counts falling edges until `wb_ack` appears and expects the count to be exactly RATIO for the wide instance and 1 for the equal-width instance. The bench's CSR model returns read data one clock after each read strobe and commits writes on the strobe edge. A monitor records the strobe addresses, the cycle of the last write strobe and the cycle of the acknowledge, and the bench requires the acknowledge to fall on the last write strobe's cycle plus one. Memory contents and the read word are compared only after the acknowledge cycle ends, against a shadow model that the bench updates on each write.

// File: rtl/wb_csr_bridge.sv
module wb_csr_bridge #(
  parameter int WB_ADDR_W  = 6,
  parameter int WB_DATA_W  = 32,
  parameter int CSR_DATA_W = 8,
  localparam int RATIO      = WB_DATA_W / CSR_DATA_W,
  localparam int LOG_R      = $clog2(RATIO),
  localparam int CSR_ADDR_W = WB_ADDR_W + LOG_R,
  localparam int SEL_W      = WB_DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WB_ADDR_W-1:0]  wb_adr,
  input  logic [WB_DATA_W-1:0]  wb_dat_w,
  output logic [WB_DATA_W-1:0]  wb_dat_r,
  input  logic [SEL_W-1:0]      wb_sel,
  input  logic                  wb_cyc,
  input  logic                  wb_stb,
  input  logic                  wb_we,
  output logic                  wb_ack,
  output logic [CSR_ADDR_W-1:0] csr_addr,
  output logic                  csr_r_stb,
  input  logic [CSR_DATA_W-1:0] csr_r_data,
  output logic                  csr_w_stb,
  output logic [CSR_DATA_W-1:0] csr_w_data
);

  localparam int CNT_W = $clog2(RATIO + 1);

  logic [CNT_W-1:0] cnt;
  logic go, last, issue;
  logic unused_sel;

  assign unused_sel = ^wb_sel;
  assign go    = wb_cyc & wb_stb & ~rst;
  assign last  = (cnt == CNT_W'(RATIO));
  assign issue = go & ~last;

  assign csr_r_stb = issue & ~wb_we;
  assign csr_w_stb = issue & wb_we;
  assign wb_ack    = go & last;

  always_ff @(posedge clk) begin
    if (rst || !go || last) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  generate
    if (RATIO == 1) begin : g_same_width
      assign csr_addr   = wb_adr;
      assign csr_w_data = wb_dat_w;
      assign wb_dat_r   = csr_r_data;
    end else begin : g_split
      logic [LOG_R-1:0] idx, idx_prev;
      logic [WB_DATA_W-CSR_DATA_W-1:0] low;

      assign idx        = cnt[LOG_R-1:0];
      assign idx_prev   = LOG_R'(cnt - 1'b1);
      assign csr_addr   = {wb_adr, idx};
      assign csr_w_data = wb_dat_w[idx*CSR_DATA_W +: CSR_DATA_W];
      assign wb_dat_r   = {csr_r_data, low};

      always_ff @(posedge clk) begin
        if (rst) low <= '0;
        else if (go && !wb_we && cnt != '0 && !last)
          low[idx_prev*CSR_DATA_W +: CSR_DATA_W] <= csr_r_data;
      end
    end
  endgenerate

  p_strobe_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (csr_r_stb || csr_w_stb) |-> (wb_cyc && wb_stb));

  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  p_ack_after_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(csr_r_stb || csr_w_stb));

  p_addr_map_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_r_stb || csr_w_stb) |-> ((csr_addr >> LOG_R) == CSR_ADDR_W'(wb_adr)));

  p_commit_with_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (csr_w_stb && ((csr_addr & CSR_ADDR_W'(RATIO - 1)) == CSR_ADDR_W'(RATIO - 1)))
    |=> (wb_ack || !(wb_cyc && wb_stb)));

  p_no_strobe_both_r1: assert property (@(posedge clk) disable iff (rst)
    !(csr_r_stb && csr_w_stb));

endmodule

// File: tb/wb_csr_bridge_bench.sv
`timescale 1ns/1ps
module wb_csr_bridge_bench;
  localparam int AW = 6, DW = 32, CW = 8, R = DW / CW, CAW = AW + 2;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic [AW-1:0] wb_adr = '0;
  logic [DW-1:0] wb_dat_w = '0, wb_dat_r;
  logic [3:0] wb_sel = '0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0, wb_ack;
  logic [CAW-1:0] csr_addr;
  logic csr_r_stb, csr_w_stb;
  logic [CW-1:0] csr_r_data, csr_w_data;

  wb_csr_bridge #(.WB_ADDR_W(AW), .WB_DATA_W(DW), .CSR_DATA_W(CW)) u_wb_csr_bridge (
    .clk(clk), .rst(rst), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_sel(wb_sel), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_ack(wb_ack),
    .csr_addr(csr_addr), .csr_r_stb(csr_r_stb), .csr_r_data(csr_r_data),
    .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data));

  logic [AW-1:0] e_adr = '0;
  logic [7:0] e_dat_w = '0, e_dat_r, e_r_data, e_w_data;
  logic [0:0] e_sel = '0;
  logic e_cyc = 0, e_stb = 0, e_we = 0, e_ack, e_r_stb, e_w_stb;
  logic [AW-1:0] e_addr;

  wb_csr_bridge #(.WB_ADDR_W(AW), .WB_DATA_W(8), .CSR_DATA_W(8)) u_wb_csr_bridge_eq (
    .clk(clk), .rst(rst), .wb_adr(e_adr), .wb_dat_w(e_dat_w), .wb_dat_r(e_dat_r),
    .wb_sel(e_sel), .wb_cyc(e_cyc), .wb_stb(e_stb), .wb_we(e_we), .wb_ack(e_ack),
    .csr_addr(e_addr), .csr_r_stb(e_r_stb), .csr_r_data(e_r_data),
    .csr_w_stb(e_w_stb), .csr_w_data(e_w_data));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic logic [DW-1:0] init_word(int a);
    logic [DW-1:0] w;
    for (int i = 0; i < R; i++) w[i*CW +: CW] = pat(a * R + i);
    return w;
  endfunction

  logic [7:0] cmem [1 << CAW];
  logic [DW-1:0] shadow [1 << AW];
  int cyc_no = 0, stb_cnt = 0, last_w = -100, ack_cyc = -100, ack_seen = 0;
  int e_stb_cnt = 0;
  logic [CAW-1:0] stb_addr [8];

  always @(posedge clk) begin
    cyc_no++;
    if (rst) begin
      for (int i = 0; i < (1 << CAW); i++) cmem[i] <= pat(i);
      csr_r_data <= '0;
      e_r_data <= '0;
    end else begin
      csr_r_data <= csr_r_stb ? cmem[csr_addr] : '0;
      if (csr_w_stb) cmem[csr_addr] <= csr_w_data;
      if (csr_r_stb || csr_w_stb) begin
        if (stb_cnt < 8) stb_addr[stb_cnt] = csr_addr;
        stb_cnt++;
        if (csr_w_stb) last_w = cyc_no;
      end
      if (wb_ack) begin ack_cyc = cyc_no; ack_seen++; end
      e_r_data <= e_r_stb ? 8'h3C : 8'h00;
      if (e_r_stb || e_w_stb) e_stb_cnt++;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(logic we, logic [AW-1:0] adr, logic [DW-1:0] dat, logic [3:0] sel,
                      output int lat, output logic [DW-1:0] rd);
    @(negedge clk);
    stb_cnt = 0;
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat_w = dat; wb_sel = sel;
    lat = 0;
    #1;
    while (!wb_ack && lat < 20) begin @(negedge clk); #1; lat++; end
    rd = wb_dat_r;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0;
    #1;
  endtask

  task automatic run_one(logic we, logic [AW-1:0] adr, logic [DW-1:0] dat, logic [3:0] sel);
    int lat;
    logic [DW-1:0] rd;
    xfer(we, adr, dat, sel, lat, rd);
    chk("R2 latency", 64'(lat), 64'(R));
    chk("R1 strobe count", 64'(stb_cnt), 64'(R));
    for (int i = 0; i < R; i++)
      chk("R3 chunk address", 64'(stb_addr[i]), 64'(adr * R + i));
    if (we) begin
      shadow[adr] = dat;
      for (int i = 0; i < R; i++)
        chk("R4 written chunk", 64'(cmem[adr * R + i]), 64'(dat[i*CW +: CW]));
      chk("R8 last write strobe precedes ack", 64'(ack_cyc - last_w), 64'd1);
    end else begin
      chk("R5 read word", 64'(rd), 64'(shadow[adr]));
    end
  endtask

  initial begin
    int lat;
    logic [DW-1:0] rd;
    void'($urandom(32'd4242));
    for (int a = 0; a < (1 << AW); a++) shadow[a] = init_word(a);

    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; e_cyc = 1; e_stb = 1;
    #1;
    chk("R9 no read strobe in reset", 64'(csr_r_stb), 64'd0);
    chk("R9 no ack in reset", 64'(wb_ack), 64'd0);
    @(negedge clk); wb_we = 1; #1;
    chk("R9 no write strobe in reset", 64'(csr_w_stb), 64'd0);
    chk("R9 narrow no strobe in reset", 64'(e_r_stb | e_w_stb | e_ack), 64'd0);
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; e_cyc = 0; e_stb = 0; rst = 0;
    @(negedge clk);

    run_one(0, 6'd3, '0, 4'hF);
    run_one(1, 6'd3, 32'hDEADBEEF, 4'hF);
    run_one(0, 6'd3, '0, 4'hF);
    run_one(1, 6'd0, 32'h01234567, 4'hF);
    run_one(1, 6'd63, 32'hFFFF0000, 4'hF);
    run_one(0, 6'd63, '0, 4'hF);

    // R6: select values do not matter
    run_one(1, 6'd10, 32'hA5A55A5A, 4'h0);
    run_one(0, 6'd10, '0, 4'h1);
    xfer(0, 6'd11, '0, 4'h8, lat, rd);
    chk("R6 latency with partial select", 64'(lat), 64'(R));
    chk("R6 strobes with partial select", 64'(stb_cnt), 64'(R));
    chk("R6 data with partial select", 64'(rd), 64'(shadow[11]));

    // R7: abandon mid-access
    @(negedge clk);
    stb_cnt = 0; ack_seen = 0;
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = 6'd20; wb_dat_w = 32'h11112222;
    @(negedge clk); @(negedge clk);
    wb_stb = 0;
    @(negedge clk); @(negedge clk);
    wb_cyc = 0;
    chk("R7 strobes before abandon", 64'(stb_cnt), 64'd2);
    chk("R7 no ack after abandon", 64'(ack_seen), 64'd0);
    chk("R7 no strobe while stb low", 64'(csr_r_stb | csr_w_stb), 64'd0);
    shadow[20][15:0] = 16'h2222;
    run_one(0, 6'd20, '0, 4'hF);

    for (int n = 0; n < 60; n++) begin
      logic w = 1'($urandom);
      run_one(w, 6'($urandom), $urandom, 4'($urandom));
    end

    // R10: equal widths
    @(negedge clk);
    e_stb_cnt = 0;
    e_cyc = 1; e_stb = 1; e_we = 0; e_adr = 6'd5;
    #1;
    chk("R10 strobe address", 64'(e_addr), 64'd5);
    chk("R10 no ack in first cycle", 64'(e_ack), 64'd0);
    @(negedge clk); #1;
    chk("R10 ack next cycle", 64'(e_ack), 64'd1);
    chk("R10 read data", 64'(e_dat_r), 64'h3C);
    @(negedge clk);
    e_cyc = 0; e_stb = 0;
    chk("R10 single access", 64'(e_stb_cnt), 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule